// File: doc/BRIEF.md
# Drowsy cache line controller

This controller tracks the supply state of every line in a small cache data array. Each line is either awake, at full voltage, or drowsy, held at a lower retention voltage that keeps its contents but leaks less. A free-running timer puts the whole array into the drowsy state at the end of every window. The line touched most recently is exempt and stays awake.

A request names a set index and a way. A request to an awake line completes in the same cycle. A request to a drowsy line holds `req_ready_o` low for a fixed wake-up penalty while that one line is brought back to full voltage. The request then completes with no miss, because the contents were kept. The per-line `drowsy_o` vector drives the supply selectors of the array. A saturating counter reports how many requests had to pay the wake-up penalty.

Top module: `drowsy_line_ctrl`

## Requirements
- R1: After reset, every bit of `drowsy_o` is 0 (all lines awake), `wake_count_o` is 0, no line is recorded as most recently used, and `req_ready_o` is 1 while no request is present.
- R2: The window counter starts at zero on reset. At the clock edge that ends every WINDOW cycles, every line becomes drowsy except the most-recently-used line. If no access has completed yet, all lines become drowsy.
- R3: A request to an awake line has `req_ready_o` high in the same cycle, causes no stall and no `wake_done_o` pulse, and leaves `drowsy_o` unchanged.
- R4: A request to a drowsy line holds `req_ready_o` low for WAKE_LAT+1 cycles, counting from the first request cycle. `wake_done_o` is high for exactly one cycle, the last stalled cycle. In the next cycle the line is awake and `req_ready_o` is high.
- R5: A wake-up clears only the `drowsy_o` bit of the addressed line. No `drowsy_o` bit goes from 1 to 0 except at a wake-up completion.
- R6: Every completed access (`req_valid_i` and `req_ready_o` both high) records its line as most recently used and replaces the previous one. The next window end exempts only the new line.
- R7: If a window end and a wake-up completion fall on the same clock edge, the line being woken is awake after that edge.
- R8: `wake_count_o` rises by one at the start of each wake-up and holds at 2^CNT_W-1 once it reaches that value.
- R9: The request addresses line number index*NUM_WAYS+way. That line's state is bit number index*NUM_WAYS+way of `drowsy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present; held until accepted |
| req_index_i | input | $clog2(NUM_SETS) | Set index of the request |
| req_way_i | input | $clog2(NUM_WAYS) | Way of the request |
| req_ready_o | output | 1 | Request accepted this cycle; low means stall |
| drowsy_o | output | NUM_SETS*NUM_WAYS | Per-line retention-voltage select, 1 = drowsy |
| wake_done_o | output | 1 | One-cycle pulse when the addressed line is back at full voltage |
| wake_count_o | output | CNT_W | Saturating count of requests that needed a wake-up |

## Verification
The bench issues requests in the following situations:
- to lines that are awake because no window has ended yet;
- to the line exempted as most recently used;
- to lines made drowsy by a window end.

Across these cases, a zero-cycle stall and a WAKE_LAT+1-cycle stall must both appear, and the stall must depend on the line's state, not on its position. After each window end, the full `drowsy_o` pattern is compared with the pattern expected for the most recent access. This shows that the exemption follows the replaced line, not the first one, and that a wake-up touches only its own bit. One request is timed so that its wake-up completes on the same edge as a window end, which tests the priority between the two. A run of wake-ups past the counter limit tests the saturation.

// File: rtl/drowsy_pkg.sv
package drowsy_pkg;
  typedef enum logic {
    WS_IDLE = 1'b0,
    WS_WAKE = 1'b1
  } wake_state_e;
endpackage

// File: rtl/drowsy_window_timer.sv
module drowsy_window_timer #(
  parameter int WINDOW = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int WIN_W = $clog2(WINDOW);

  logic [WIN_W-1:0] cnt_q;

  assign tick_o = (cnt_q == WIN_W'(WINDOW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/drowsy_wake_seq.sv
module drowsy_wake_seq
  import drowsy_pkg::*;
#(
  parameter int WAKE_LAT = 2,
  parameter int LINE_W   = 4,
  parameter int CNT_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [LINE_W-1:0] done_line_o,
  output logic [CNT_W-1:0]  wake_count_o
);
  localparam int WCNT_W = $clog2(WAKE_LAT + 1);

  wake_state_e       state_q;
  logic [WCNT_W-1:0] wcnt_q;
  logic [LINE_W-1:0] line_q;
  logic [CNT_W-1:0]  cnt_q;

  assign busy_o       = (state_q == WS_WAKE);
  assign done_o       = busy_o && (wcnt_q == '0);
  assign done_line_o  = line_q;
  assign wake_count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      wcnt_q  <= '0;
      line_q  <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        WS_IDLE: if (start_i) begin
          state_q <= WS_WAKE;
          wcnt_q  <= WCNT_W'(WAKE_LAT - 1);
          line_q  <= line_i;
          if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        end
        WS_WAKE: begin
          if (wcnt_q == '0) state_q <= WS_IDLE;
          else              wcnt_q  <= wcnt_q - 1'b1;
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/drowsy_line_state.sv
module drowsy_line_state #(
  parameter int LINES  = 16,
  parameter int LINE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              acc_i,
  input  logic [LINE_W-1:0] acc_line_i,
  input  logic              wake_i,
  input  logic [LINE_W-1:0] wake_line_i,
  output logic [LINES-1:0]  drowsy_o
);
  logic [LINE_W-1:0] mru_q, mru_d;
  logic              mru_vld_q, mru_vld_d;

  // exemption follows an access that completes on the window edge
  assign mru_d     = acc_i ? acc_line_i : mru_q;
  assign mru_vld_d = acc_i | mru_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mru_q     <= '0;
      mru_vld_q <= 1'b0;
    end else begin
      mru_q     <= mru_d;
      mru_vld_q <= mru_vld_d;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      q <= 1'b0;
      else if (wake_i && wake_line_i == LINE_W'(g))     q <= 1'b0;
      else if (tick_i) q <= !(mru_vld_d && mru_d == LINE_W'(g));
    end
    assign drowsy_o[g] = q;
  end
endmodule

// File: rtl/drowsy_line_ctrl.sv
module drowsy_line_ctrl #(
  parameter int NUM_SETS = 8,
  parameter int NUM_WAYS = 2,
  parameter int WINDOW   = 4000,
  parameter int WAKE_LAT = 2,
  parameter int CNT_W    = 8,
  localparam int LINES   = NUM_SETS * NUM_WAYS,
  localparam int IDX_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [IDX_W-1:0] req_index_i,
  input  logic [WAY_W-1:0] req_way_i,
  output logic             req_ready_o,
  output logic [LINES-1:0] drowsy_o,
  output logic             wake_done_o,
  output logic [CNT_W-1:0] wake_count_o
);
  localparam int LINE_W = $clog2(LINES);

  logic [LINE_W-1:0] req_line, done_line;
  logic              tick, busy, start, acc;

  assign req_line    = LINE_W'(req_index_i) * LINE_W'(NUM_WAYS) + LINE_W'(req_way_i);
  assign start       = req_valid_i && !busy && drowsy_o[req_line];
  assign req_ready_o = !busy && !(req_valid_i && drowsy_o[req_line]);
  assign acc         = req_valid_i && req_ready_o;

  drowsy_window_timer #(.WINDOW(WINDOW)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  drowsy_wake_seq #(
    .WAKE_LAT(WAKE_LAT),
    .LINE_W  (LINE_W),
    .CNT_W   (CNT_W)
  ) i_wake (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .line_i      (req_line),
    .busy_o      (busy),
    .done_o      (wake_done_o),
    .done_line_o (done_line),
    .wake_count_o(wake_count_o)
  );

  drowsy_line_state #(
    .LINES (LINES),
    .LINE_W(LINE_W)
  ) i_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .acc_i      (acc),
    .acc_line_i (req_line),
    .wake_i     (wake_done_o),
    .wake_line_i(done_line),
    .drowsy_o   (drowsy_o)
  );
endmodule

// File: rtl/drowsy_line_ctrl_chk.sv
module drowsy_line_ctrl_chk #(
  parameter int NUM_SETS = 8,
  parameter int NUM_WAYS = 2,
  parameter int CNT_W    = 8,
  localparam int LINES   = NUM_SETS * NUM_WAYS,
  localparam int IDX_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int LINE_W  = $clog2(LINES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [IDX_W-1:0] req_index_i,
  input logic [WAY_W-1:0] req_way_i,
  input logic             req_ready_o,
  input logic [LINES-1:0] drowsy_o,
  input logic             wake_done_o,
  input logic [CNT_W-1:0] wake_count_o
);
  logic [LINE_W-1:0] line;
  assign line = LINE_W'(req_index_i) * LINE_W'(NUM_WAYS) + LINE_W'(req_way_i);

  assert_drowsy_stall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && drowsy_o[line]) |-> !req_ready_o);

  assert_wake_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done_o |=> !wake_done_o);

  assert_no_stray_wake_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wake_done_o |=> (($past(drowsy_o) & ~drowsy_o) == '0));

  assert_woken_awake_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_done_o && req_valid_i) |=> !drowsy_o[$past(line)]);

  assert_count_monotonic_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (wake_count_o >= $past(wake_count_o)));
endmodule

bind drowsy_line_ctrl drowsy_line_ctrl_chk #(
  .NUM_SETS(NUM_SETS),
  .NUM_WAYS(NUM_WAYS),
  .CNT_W   (CNT_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_index_i (req_index_i),
  .req_way_i   (req_way_i),
  .req_ready_o (req_ready_o),
  .drowsy_o    (drowsy_o),
  .wake_done_o (wake_done_o),
  .wake_count_o(wake_count_o)
);

// File: tb/test_drowsy_line_ctrl.sv
`timescale 1ns/1ps
module test_drowsy_line_ctrl;
  localparam int NUM_SETS = 8;
  localparam int NUM_WAYS = 2;
  localparam int WINDOW   = 64;
  localparam int WAKE_LAT = 2;
  localparam int CNT_W    = 3;
  localparam int LINES    = NUM_SETS * NUM_WAYS;
  localparam int CNT_MAX  = (1 << CNT_W) - 1;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid_i = 1'b0;
  logic [2:0]       req_index_i = '0;
  logic [0:0]       req_way_i = '0;
  logic             req_ready_o;
  logic [LINES-1:0] drowsy_o;
  logic             wake_done_o;
  logic [CNT_W-1:0] wake_count_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  int wakes_issued = 0;

  int    exp_stall[$];
  string exp_tag[$];

  always #2.5 clk_i = ~clk_i;

  drowsy_line_ctrl #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .WINDOW(WINDOW),
    .WAKE_LAT(WAKE_LAT), .CNT_W(CNT_W)
  ) i_drowsy_line_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .req_index_i(req_index_i), .req_way_i(req_way_i), .req_ready_o(req_ready_o),
    .drowsy_o(drowsy_o), .wake_done_o(wake_done_o), .wake_count_o(wake_count_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [LINES-1:0] bit_of(input int line);
    return LINES'(1) << line;
  endfunction

  // driver: push the expected stall, then hold the request until accepted
  task automatic access(input int idx, input int way, input int stall, input string tag);
    exp_stall.push_back(stall);
    exp_tag.push_back(tag);
    if (stall > 0) wakes_issued++;
    @(posedge clk_i) #1;
    req_valid_i = 1'b1;
    req_index_i = 3'(idx);
    req_way_i   = 1'(way);
    forever begin
      @(negedge clk_i);
      if (req_ready_o) break;
    end
    @(posedge clk_i) #1;
    req_valid_i = 1'b0;
  endtask

  // monitor: measure each transaction and compare with the queue head
  int st_cnt = 0;
  int wk_cnt = 0;
  always @(negedge clk_i) begin
    if (rst_ni && req_valid_i) begin
      if (wake_done_o) wk_cnt++;
      if (!req_ready_o) st_cnt++;
      else begin
        if (exp_stall.size() == 0) begin
          chk(1'b0, "R3 unexpected access", 0, 0);
        end else begin
          automatic int    es = exp_stall.pop_front();
          automatic string tg = exp_tag.pop_front();
          chk(st_cnt == es, {tg, " stall"}, st_cnt, es);
          chk(wk_cnt == (es > 0 ? 1 : 0), {tg, " wake_done"}, wk_cnt, (es > 0 ? 1 : 0));
        end
        st_cnt = 0;
        wk_cnt = 0;
      end
    end
  end

  task automatic wait_tick_change();
    automatic logic [LINES-1:0] prev = drowsy_o;
    forever begin
      @(negedge clk_i);
      if (drowsy_o != prev) break;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  localparam int STALL = WAKE_LAT + 1;

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(drowsy_o == '0, "R1 drowsy_o", drowsy_o, 0);
    chk(wake_count_o == '0, "R1 wake_count", wake_count_o, 0);
    chk(req_ready_o == 1'b1, "R1 ready idle", req_ready_o, 1);

    // R3: awake lines before any window end
    access(0, 0, 0, "R3 awake line 0");
    chk(drowsy_o == '0, "R3 drowsy unchanged", drowsy_o, 0);
    access(5, 1, 0, "R3 awake line 11");

    // R2 R6: exemption follows the latest access (line 11), not line 0
    wait_tick_change();
    chk(drowsy_o == ~bit_of(11), "R2 R6 window pattern", drowsy_o, ~bit_of(11));

    access(5, 1, 0, "R3 mru line stays awake");

    // R4 R5 R9: line 3*2+1 = 7 is drowsy
    access(3, 1, STALL, "R4 drowsy line 7");
    chk(drowsy_o == (~bit_of(11) & ~bit_of(7)), "R5 R9 only line 7 woke",
        drowsy_o, ~bit_of(11) & ~bit_of(7));
    chk(wake_count_o == 1, "R8 count one", wake_count_o, 1);

    // R7: the wake-up of line 4 completes on the next window edge
    wait_tick_change();
    chk(drowsy_o == ~bit_of(7), "R6 exempt line 7", drowsy_o, ~bit_of(7));
    repeat (WINDOW - WAKE_LAT - 2) @(posedge clk_i);
    access(2, 0, STALL, "R7 wake on window edge");
    chk(drowsy_o == ~(bit_of(4) | bit_of(7)), "R7 woken line awake",
        drowsy_o, ~(bit_of(4) | bit_of(7)));

    // R8: saturate the counter
    access(4, 0, STALL, "R8 wake 8");
    access(4, 1, STALL, "R8 wake 9");
    access(5, 0, STALL, "R8 wake 10");
    access(6, 0, STALL, "R8 wake 12");
    access(6, 1, STALL, "R8 wake 13");
    access(7, 0, STALL, "R8 wake 14");
    access(7, 1, STALL, "R8 wake 15");
    chk(wake_count_o == CNT_W'(wakes_issued > CNT_MAX ? CNT_MAX : wakes_issued),
        "R8 saturated count", wake_count_o, CNT_MAX);
    access(7, 1, 0, "R3 line 15 now awake");
    chk(wake_count_o == CNT_MAX, "R8 count holds", wake_count_o, CNT_MAX);

    repeat (2) @(negedge clk_i);
    chk(exp_stall.size() == 0, "R4 scoreboard drained", exp_stall.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule